// File: doc/BRIEF.md
# Sticky Interrupt Status Aggregator

This block gathers one-cycle error and event pulses from the bus interfaces of a PCI address-translation function into a 32-bit status register of sticky bits. A second 32-bit companion status register holds its own copy of five of those events. Both copies set on the same clock edge, and software clears each copy on its own by writing ones to it. A registered, level-sensitive interrupt request stays high while any bit that may interrupt is set.

Some set conditions are qualified rather than taken straight from a pulse. The power-state-transition bit sets only on a write of the power-state field that moves between D0 and D3 while the transition mask is clear. The detected-parity bit logs some kinds of parity error and drops read-data errors on transfers mastered by a DMA channel. Software uses a simple register port: a registered read with one select bit, and a write with one select bit whose set data bits clear the matching status bits.

Top module: `irq_status_agg`

## Requirements
- R1: After a synchronous reset, both registers read 0x0000_0000 and `irq` is low. The power-state tracker starts at D0.
- R2: Each of the five low events sets a status bit and a companion bit on the same edge. The status bits and the companion bits they map to are: bit 0 (data parity reported as master) to 8, bit 1 (target abort signalled) to 11, bit 2 (target abort received) to 12, bit 3 (PCI-side master abort) to 13, and bit 4 (SERR# seen on the bus) to 14.
- R3: Set bits stay set. A write with `wr_sel`=0 clears each status bit whose data bit is 1 and leaves bits written with 0 unchanged. `wr_sel`=1 does the same on the companion register.
- R4: Clearing a bit in one register never clears its mirror in the other.
- R5: When a set event and a write-1 clear hit the same bit on the same edge, the bit ends up set.
- R6: Status bit 11 sets when `pm_wr` writes `pm_state` from D0 (2'b00) to D3 (2'b11), or from D3 to D0, while `pm_mask` is 0. Every power-state write updates the tracked state.
- R7: Bit 11 does not set when the transition is masked, when the write leaves the state unchanged, or when the old or new state is D1 (2'b01) or D2 (2'b10).
- R8: When `par_err` pulses, status bit 9 sets for `par_kind` 0 (write data received as target), for kind 2 (address parity, loopback included) and for kind 1 (read data as master) with `par_dma`=0. It does not set for kind 1 with `par_dma`=1, or for kind 3.
- R9: The internal-bus master abort sets only bit 7, and SERR# driven by this function sets only bit 10. Neither of them is mirrored.
- R10: `irq` equals, one cycle late, the OR of status bits 4:0, 7, 9, 11 and 12. It rises one cycle after the first such bit sets and falls one cycle after the last one clears. Bit 10 alone does not raise it.
- R11: Reserved bits read as zero and ignore writes. The status register implements bits 0-4, 7 and 9-11, and the companion register implements bits 8 and 11-14. `rd_data` is registered: it shows the register picked by `rd_sel` (0 status, 1 companion) one cycle later, and a read changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_mperr_rpt | input | 1 | Pulse: data parity error reported as master |
| ev_tabort_sig | input | 1 | Pulse: target abort signalled |
| ev_tabort_rcv | input | 1 | Pulse: target abort received |
| ev_pci_mabort | input | 1 | Pulse: master abort on the PCI master |
| ev_serr_seen | input | 1 | Pulse: SERR# observed on the bus |
| ev_ib_mabort | input | 1 | Pulse: master abort on the internal bus master |
| ev_serr_drv | input | 1 | Pulse: SERR# driven by this function |
| par_err | input | 1 | Pulse: a parity error was detected |
| par_kind | input | 2 | Parity error kind (see R8) |
| par_dma | input | 1 | The transfer was mastered by a DMA channel |
| pm_wr | input | 1 | Power-state field write strobe |
| pm_state | input | 2 | New power state being written |
| pm_mask | input | 1 | Masks the power-transition status bit |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 status, 1 companion |
| wr_data | input | 32 | Write-1-to-clear data |
| rd_sel | input | 1 | Read target: 0 status, 1 companion |
| rd_data | output | 32 | Registered read data |
| irq | output | 1 | Registered level interrupt request |

## Verification
A qualified set and a software clear of the same bit can land on the same clock edge, and the set must win. The bench provokes this by raising an event and a write of a 1 to the matching bit in the same cycle, to each of the two registers in turn. It then reads both registers back and expects the bit still set in both. In a second collision, one register is cleared while the event also sets its mirror. That case confirms that neither register's clear leaks into the other.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int REG_W    = 32;
  localparam int N_MIRROR = 5;

  localparam int B_IBMA   = 7;
  localparam int B_PERR   = 9;
  localparam int B_SERRD  = 10;
  localparam int B_PMT    = 11;

  localparam logic [REG_W-1:0] STAT_IMPL = 32'h0000_0E9F;
  localparam logic [REG_W-1:0] COMP_IMPL = 32'h0000_7900;
  localparam logic [REG_W-1:0] IRQ_MASK  = 32'h0000_1A9F;

  typedef enum logic [1:0] {
    PS_D0 = 2'b00,
    PS_D1 = 2'b01,
    PS_D2 = 2'b10,
    PS_D3 = 2'b11
  } pstate_e;

  typedef enum logic [1:0] {
    PK_TGT_WDATA = 2'd0,
    PK_MST_RDATA = 2'd1,
    PK_ADDR      = 2'd2,
    PK_NONE      = 2'd3
  } pkind_e;

  function automatic int mirror_pos(input int i);
    return (i == 0) ? 8 : 10 + i;
  endfunction
endpackage

// File: rtl/irq_ev_qual.sv
module irq_ev_qual
  import irq_agg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [N_MIRROR-1:0] ev_low,
  input  logic             ev_ib_mabort,
  input  logic             ev_serr_drv,
  input  logic             par_err,
  input  logic [1:0]       par_kind,
  input  logic             par_dma,
  input  logic             pm_wr,
  input  logic [1:0]       pm_state,
  input  logic             pm_mask,
  output logic [REG_W-1:0] set_vec
);
  pstate_e ps_q;
  pstate_e ps_new;
  pkind_e  kind;
  logic    pm_hit;
  logic    par_hit;

  assign ps_new = pstate_e'(pm_state);
  assign kind   = pkind_e'(par_kind);

  always_ff @(posedge clk) begin
    if (rst)         ps_q <= PS_D0;
    else if (pm_wr)  ps_q <= ps_new;
  end

  always_comb begin
    pm_hit = 1'b0;
    if (pm_wr && !pm_mask) begin
      if ((ps_q == PS_D0 && ps_new == PS_D3) ||
          (ps_q == PS_D3 && ps_new == PS_D0))
        pm_hit = 1'b1;
    end
  end

  always_comb begin
    par_hit = 1'b0;
    if (par_err) begin
      case (kind)
        PK_TGT_WDATA: par_hit = 1'b1;
        PK_MST_RDATA: par_hit = !par_dma;
        PK_ADDR:      par_hit = 1'b1;
        default:      par_hit = 1'b0;
      endcase
    end
  end

  always_comb begin
    set_vec = '0;
    set_vec[N_MIRROR-1:0] = ev_low;
    set_vec[B_IBMA]  = ev_ib_mabort;
    set_vec[B_PERR]  = par_hit;
    set_vec[B_SERRD] = ev_serr_drv;
    set_vec[B_PMT]   = pm_hit;
  end

  // R7: a masked power-state write never flags a transition
  assert_pm_masked_R7: assert property (@(posedge clk) disable iff (rst)
    (pm_wr && pm_mask) |-> !set_vec[B_PMT]);

  // R6: the tracked state follows every power-state write
  assert_pm_track_R6: assert property (@(posedge clk) disable iff (rst)
    pm_wr |=> (ps_q == $past(ps_new)));
endmodule

// File: rtl/irq_sticky_bank.sv
module irq_sticky_bank #(
  parameter int                 W    = 32,
  parameter logic [W-1:0]       IMPL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set,
  input  logic [W-1:0] clr,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= (set | (q & ~clr)) & IMPL;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (IMPL[i]) begin : g_impl
      // R5: a set on the same edge as a clear leaves the bit set
      assert_set_wins_R5: assert property (@(posedge clk) disable iff (rst)
        set[i] |=> q[i]);
      // R3: write-1 clears the bit
      assert_w1c_R3: assert property (@(posedge clk) disable iff (rst)
        (clr[i] && !set[i]) |=> !q[i]);
      // R3: bits hold without set or clear
      assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (!clr[i] && !set[i]) |=> $stable(q[i]));
    end else begin : g_resv
      // R11: reserved bits stay zero
      assert_resv_zero_R11: assert property (@(posedge clk) disable iff (rst)
        !q[i]);
    end
  end
endmodule

// File: rtl/irq_req_gen.sv
module irq_req_gen #(
  parameter int               W    = 32,
  parameter logic [W-1:0]     MASK = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] stat,
  output logic         irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(stat & MASK);
  end
endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg
  import irq_agg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_mperr_rpt,
  input  logic             ev_tabort_sig,
  input  logic             ev_tabort_rcv,
  input  logic             ev_pci_mabort,
  input  logic             ev_serr_seen,
  input  logic             ev_ib_mabort,
  input  logic             ev_serr_drv,
  input  logic             par_err,
  input  logic [1:0]       par_kind,
  input  logic             par_dma,
  input  logic             pm_wr,
  input  logic [1:0]       pm_state,
  input  logic             pm_mask,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic             rd_sel,
  output logic [REG_W-1:0] rd_data,
  output logic             irq
);
  logic [N_MIRROR-1:0] ev_low;
  logic [REG_W-1:0]    set_stat;
  logic [REG_W-1:0]    set_comp;
  logic [REG_W-1:0]    clr_stat;
  logic [REG_W-1:0]    clr_comp;
  logic [REG_W-1:0]    stat_q;
  logic [REG_W-1:0]    comp_q;

  assign ev_low = {ev_serr_seen, ev_pci_mabort, ev_tabort_rcv,
                   ev_tabort_sig, ev_mperr_rpt};

  irq_ev_qual u_qual (
    .clk          (clk),
    .rst          (rst),
    .ev_low       (ev_low),
    .ev_ib_mabort (ev_ib_mabort),
    .ev_serr_drv  (ev_serr_drv),
    .par_err      (par_err),
    .par_kind     (par_kind),
    .par_dma      (par_dma),
    .pm_wr        (pm_wr),
    .pm_state     (pm_state),
    .pm_mask      (pm_mask),
    .set_vec      (set_stat)
  );

  always_comb begin
    set_comp = '0;
    for (int i = 0; i < N_MIRROR; i++)
      set_comp[mirror_pos(i)] = set_stat[i];
  end

  assign clr_stat = (wr_en && !wr_sel) ? wr_data : '0;
  assign clr_comp = (wr_en &&  wr_sel) ? wr_data : '0;

  irq_sticky_bank #(.W(REG_W), .IMPL(STAT_IMPL)) u_stat (
    .clk (clk), .rst (rst), .set (set_stat), .clr (clr_stat), .q (stat_q)
  );

  irq_sticky_bank #(.W(REG_W), .IMPL(COMP_IMPL)) u_comp (
    .clk (clk), .rst (rst), .set (set_comp), .clr (clr_comp), .q (comp_q)
  );

  irq_req_gen #(.W(REG_W), .MASK(IRQ_MASK)) u_irq (
    .clk (clk), .rst (rst), .stat (stat_q), .irq (irq)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_sel ? comp_q : stat_q;
  end

  // R2: a low status bit rising brings its companion copy with it
  for (genvar m = 0; m < N_MIRROR; m++) begin : g_mir
    assert_mirror_R2: assert property (@(posedge clk) disable iff (rst)
      $rose(stat_q[m]) |-> comp_q[mirror_pos(m)]);
  end

  // R10: irq follows the interrupt-capable bits one cycle late
  assert_irq_lag_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq == $past(|(stat_q & IRQ_MASK))));

  // R11: reserved positions never read back as one
  assert_rd_resv_R11: assert property (@(posedge clk) disable iff (rst)
    (rd_data & ~(STAT_IMPL | COMP_IMPL)) == '0);

  // R4: a status-only clear leaves the companion register untouched
  assert_indep_R4: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_sel) |=> ((comp_q & $past(comp_q)) == $past(comp_q)));
endmodule

// File: tb/sim_irq_status_agg.sv
`timescale 1ns/1ps
module sim_irq_status_agg;
  logic        clk = 1'b0;
  logic        rst;
  logic        ev_mperr_rpt, ev_tabort_sig, ev_tabort_rcv, ev_pci_mabort;
  logic        ev_serr_seen, ev_ib_mabort, ev_serr_drv;
  logic        par_err, par_dma, pm_wr, pm_mask;
  logic [1:0]  par_kind, pm_state;
  logic        wr_en, wr_sel, rd_sel;
  logic [31:0] wr_data, rd_data;
  logic        irq;
  int          total = 0;
  int          bad   = 0;

  always #2.5 clk = ~clk;

  irq_status_agg u0 (
    .clk(clk), .rst(rst),
    .ev_mperr_rpt(ev_mperr_rpt), .ev_tabort_sig(ev_tabort_sig),
    .ev_tabort_rcv(ev_tabort_rcv), .ev_pci_mabort(ev_pci_mabort),
    .ev_serr_seen(ev_serr_seen), .ev_ib_mabort(ev_ib_mabort),
    .ev_serr_drv(ev_serr_drv), .par_err(par_err), .par_kind(par_kind),
    .par_dma(par_dma), .pm_wr(pm_wr), .pm_state(pm_state), .pm_mask(pm_mask),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel),
    .rd_data(rd_data), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic idle();
    ev_mperr_rpt = 0; ev_tabort_sig = 0; ev_tabort_rcv = 0; ev_pci_mabort = 0;
    ev_serr_seen = 0; ev_ib_mabort = 0; ev_serr_drv = 0;
    par_err = 0; par_kind = 0; par_dma = 0;
    pm_wr = 0; pm_state = 0;
    wr_en = 0; wr_sel = 0; wr_data = 0;
  endtask

  task automatic step();
    @(negedge clk); idle();
  endtask

  task automatic rd(input logic sel, output logic [31:0] v);
    @(negedge clk); rd_sel = sel;
    @(negedge clk); v = rd_data;
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_sel = sel; wr_data = d;
    step();
  endtask

  task automatic expect_regs(input string tag, input logic [31:0] s, input logic [31:0] c);
    logic [31:0] v;
    rd(1'b0, v); chk({tag, " status"}, v, s);
    rd(1'b1, v); chk({tag, " companion"}, v, c);
  endtask

  task automatic clear_all();
    wr(1'b0, 32'hFFFF_FFFF);
    wr(1'b1, 32'hFFFF_FFFF);
    step();
  endtask

  task automatic pm_write(input logic [1:0] st, input logic msk);
    @(negedge clk); pm_wr = 1; pm_state = st; pm_mask = msk;
    step();
  endtask

  task automatic par_pulse(input logic [1:0] k, input logic dma);
    @(negedge clk); par_err = 1; par_kind = k; par_dma = dma;
    step();
  endtask

  task automatic t_reset();
    expect_regs("R1 reset", 32'h0, 32'h0);
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_mirror();
    @(negedge clk); ev_pci_mabort = 1;
    step();
    chk("R10 irq lags set by one cycle", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R10 irq rises", {31'b0, irq}, 32'h1);
    expect_regs("R2 bit3->13", 32'h0000_0008, 32'h0000_2000);
    @(negedge clk); ev_mperr_rpt = 1;
    step();
    expect_regs("R2 bit0->8", 32'h0000_0009, 32'h0000_2100);
  endtask

  task automatic t_w1c();
    wr(1'b0, 32'h0);
    expect_regs("R3 write zero keeps", 32'h0000_0009, 32'h0000_2100);
    wr(1'b0, 32'h0000_0008);
    expect_regs("R4 status clear keeps companion", 32'h0000_0001, 32'h0000_2100);
    wr(1'b1, 32'h0000_0100);
    expect_regs("R4 companion clear keeps status", 32'h0000_0001, 32'h0000_2000);
    wr(1'b0, 32'h0000_0001);
    chk("R10 irq still high one cycle after clear", {31'b0, irq}, 32'h1);
    @(negedge clk);
    chk("R10 irq falls", {31'b0, irq}, 32'h0);
    clear_all();
    expect_regs("R3 clear all", 32'h0, 32'h0);
  endtask

  task automatic t_setwins();
    @(negedge clk); ev_serr_seen = 1; wr_en = 1; wr_sel = 0; wr_data = 32'h10;
    step();
    expect_regs("R5 set beats status clear", 32'h0000_0010, 32'h0000_4000);
    @(negedge clk); ev_serr_seen = 1; wr_en = 1; wr_sel = 1; wr_data = 32'h4000;
    step();
    expect_regs("R5 set beats companion clear", 32'h0000_0010, 32'h0000_4000);
    @(negedge clk); ev_tabort_rcv = 1; wr_en = 1; wr_sel = 0; wr_data = 32'hFFFF_FFFF;
    step();
    expect_regs("R4 R5 status clear with new event", 32'h0000_0004, 32'h0000_5000);
    clear_all();
  endtask

  task automatic t_pm();
    pm_write(2'b11, 1'b0);
    expect_regs("R6 D0->D3", 32'h0000_0800, 32'h0);
    @(negedge clk);
    chk("R10 irq from bit11", {31'b0, irq}, 32'h1);
    clear_all();
    pm_write(2'b11, 1'b0);
    expect_regs("R7 unchanged D3", 32'h0, 32'h0);
    pm_write(2'b00, 1'b0);
    expect_regs("R6 D3->D0", 32'h0000_0800, 32'h0);
    clear_all();
    pm_write(2'b01, 1'b0);
    pm_write(2'b11, 1'b0);
    expect_regs("R7 via D1", 32'h0, 32'h0);
    pm_write(2'b00, 1'b1);
    expect_regs("R7 masked D3->D0", 32'h0, 32'h0);
    pm_write(2'b10, 1'b0);
    pm_write(2'b00, 1'b0);
    expect_regs("R7 via D2", 32'h0, 32'h0);
    pm_write(2'b11, 1'b0);
    expect_regs("R6 D0->D3 again", 32'h0000_0800, 32'h0);
    clear_all();
  endtask

  task automatic t_parity();
    par_pulse(2'd0, 1'b0);
    expect_regs("R8 target write data", 32'h0000_0200, 32'h0);
    clear_all();
    par_pulse(2'd1, 1'b1);
    expect_regs("R8 DMA read data ignored", 32'h0, 32'h0);
    par_pulse(2'd1, 1'b0);
    expect_regs("R8 master read data", 32'h0000_0200, 32'h0);
    clear_all();
    par_pulse(2'd2, 1'b1);
    expect_regs("R8 address parity", 32'h0000_0200, 32'h0);
    clear_all();
    par_pulse(2'd3, 1'b0);
    expect_regs("R8 kind 3 ignored", 32'h0, 32'h0);
  endtask

  task automatic t_bits();
    @(negedge clk); ev_serr_drv = 1;
    step();
    expect_regs("R9 serr driven bit10", 32'h0000_0400, 32'h0);
    chk("R10 bit10 no irq", {31'b0, irq}, 32'h0);
    clear_all();
    @(negedge clk); ev_ib_mabort = 1;
    step();
    expect_regs("R9 internal abort bit7", 32'h0000_0080, 32'h0);
    chk("R10 bit7 irq", {31'b0, irq}, 32'h1);
    clear_all();
    @(negedge clk); ev_tabort_sig = 1;
    step();
    expect_regs("R2 bit1->11", 32'h0000_0002, 32'h0000_0800);
    clear_all();
  endtask

  task automatic t_reserved();
    logic [31:0] a, b;
    @(negedge clk); ev_tabort_rcv = 1; ev_ib_mabort = 1;
    step();
    wr(1'b0, 32'hFFFF_F160);
    wr(1'b1, 32'hFFFF_86FF);
    expect_regs("R11 reserved writes ignored", 32'h0000_0084, 32'h0000_1000);
    rd(1'b0, a);
    rd(1'b0, b);
    chk("R11 read no side effect", b, a);
    clear_all();
  endtask

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'h1, 32'h0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle();
    pm_mask = 0; rd_sel = 0; rst = 1;
    repeat (4) @(negedge clk);
    rst = 0;
    t_reset();
    t_mirror();
    t_w1c();
    t_setwins();
    t_pm();
    t_parity();
    t_bits();
    t_reserved();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule